// File: doc/BRIEF.md
# Banked Interrupt Trigger Controller

This block gathers a set of external interrupt lines, up to four banks of 32 lines each, and steers every line onto one of four per-thread trigger outputs. Every bank holds three 32-bit registers. A status register records events. A sense register picks edge or level capture for each line. A mask register lets a pending line reach the core or keeps it back. Every line also has a vector register. The vector names the single thread trigger the line drives, or disconnects the line from all of them.

Software reaches every register through a word-wide port that reads and writes in one cycle. Writing a one to a status bit flips it. A handler can therefore clear an edge event, or raise a fresh event by setting the bit again. Each thread trigger is the OR of all lines that are pending, unmasked and routed to that thread.

Top module: `trig_ctrl`

## Requirements
- R1: After reset, every status, sense, mask and vector register reads zero and all four thread triggers are low.
- R2: Registers sit at byte addresses in a 16-bit space. Status of bank b is at 0x000+8b, sense at 0x040+8b and mask at 0x080+8b. The vector of line k in bank b is at 0x1000*(b+1)+8k. Any other address, and any address with a nonzero value in bits 2:0, reads zero and ignores writes. Read data appears on the cycle after the read request, marked by a valid flag.
- R3: On an edge line (sense bit 0), a rising edge of the input sets its status bit. The bit becomes visible on the third clock edge after the input rises: two synchroniser flops, then capture.
- R4: On an edge line, writing 1 to a status bit flips it, and writing 0 leaves it unchanged. A rising edge in the same cycle as a flipping write leaves the bit set.
- R5: On a level line (sense bit 1), the status bit follows the synchronised input with the same three-edge delay. Status writes have no lasting effect on it.
- R6: A line reaches a trigger only while its mask bit is 1. Its status bit keeps recording events while the mask bit is 0.
- R7: A vector register keeps only bit 4 (valid) and bits 1:0 (thread index), and all other bits read as zero. With valid clear, the line drives no trigger.
- R8: Thread trigger t is the OR, over all lines, of status AND mask for every line whose valid vector selects t. A line drives exactly one thread.
- R9: The bank count is a parameter from 1 to 4. Registers of banks that are not built read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_BANKS*32 | External interrupt lines, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 16 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| reg_rvalid | output | 1 | Read data valid |
| thr_trig | output | 4 | Per-thread trigger outputs |

## Verification
The bench builds three banks, so a fourth, unbuilt bank can be probed. The capture path is driven in several ways:
- An input edge alone, sampled one edge early and exactly on time, which separates a correct synchroniser depth from a shallower or deeper one.
- Toggle writes of one and of zero on an idle line, which separate a flip from a plain clear.
- A flipping write that lands in the same cycle as a rising edge while the bit is already set, which exposes which of the two wins.
- A level line with a status write, showing that the input and not the write sets the bit.

Routing is tried by moving one pending line between threads, by invalidating its vector, and by holding two lines on one thread while one of them clears. These cases separate a correct OR from a last-writer or single-line selection.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int LINES_PER_BANK = 32;
  localparam int NUM_THREADS    = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_SENS,
    SEL_MASK,
    SEL_VEC
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e   kind;
    logic [1:0]  bank;
    logic [4:0]  bitn;
  } reg_sel_t;

  // Address decode; nb is the number of banks that exist.
  function automatic reg_sel_t decode_addr(input logic [15:0] a, input int nb);
    reg_sel_t s;
    s.kind = SEL_NONE;
    s.bank = '0;
    s.bitn = '0;
    if (a[2:0] == 3'b000) begin
      if (a[15:8] == 8'h00) begin
        if (int'(a[5:3]) < nb) begin
          s.bank = a[4:3];
          case (a[7:6])
            2'd0:    s.kind = SEL_STAT;
            2'd1:    s.kind = SEL_SENS;
            2'd2:    s.kind = SEL_MASK;
            default: s.kind = SEL_NONE;
          endcase
        end
      end else if (a[11:8] == 4'h0 && a[15:12] != 4'h0 && int'(a[15:12]) <= nb) begin
        s.kind = SEL_VEC;
        s.bank = 2'(a[15:12] - 4'd1);
        s.bitn = a[7:3];
      end
    end
    return s;
  endfunction

  // Next status for one bank: level lines follow the input,
  // edge lines set on a rise, otherwise flip where toggled.
  function automatic logic [31:0] next_status(input logic [31:0] cur,
                                              input logic [31:0] sense,
                                              input logic [31:0] lvl,
                                              input logic [31:0] rise,
                                              input logic [31:0] tog);
    logic [31:0] edge_nx;
    edge_nx = rise | (cur ^ tog);
    return (sense & lvl) | (~sense & edge_nx);
  endfunction

  // Software view of a stored vector: valid at bit 4, thread at 1:0.
  function automatic logic [31:0] vec_word(input logic v, input logic [1:0] t);
    return {27'd0, v, 2'b00, t};
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] sync_i,
  input  logic [31:0] rise_i,
  input  logic        stat_we,
  input  logic        sens_we,
  input  logic        mask_we,
  input  logic        vec_we,
  input  logic [4:0]  vec_bit,
  input  logic [31:0] wdata,
  output logic [31:0] status_o,
  output logic [31:0] sense_o,
  output logic [31:0] mask_o,
  output logic [31:0] pend_o,
  output logic [31:0] tog_o,
  output logic [31:0] vvalid_o,
  output logic [63:0] vthr_o
);
  logic [31:0] status_q, sense_q, mask_q;

  assign tog_o = stat_we ? wdata : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      sense_q  <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= next_status(status_q, sense_q, sync_i, rise_i, tog_o);
      if (sens_we) sense_q <= wdata;
      if (mask_we) mask_q  <= wdata;
    end
  end

  for (genvar k = 0; k < LINES_PER_BANK; k++) begin : g_vec
    logic       v_q;
    logic [1:0] t_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= 2'd0;
      end else if (vec_we && vec_bit == 5'(k)) begin
        v_q <= wdata[4];
        t_q <= wdata[1:0];
      end
    end
    assign vvalid_o[k]       = v_q;
    assign vthr_o[2*k +: 2]  = t_q;
  end

  assign status_o = status_q;
  assign sense_o  = sense_q;
  assign mask_o   = mask_q;
  assign pend_o   = status_q & mask_q;
endmodule

// File: rtl/trig_route.sv
module trig_route #(
  parameter int N  = 128,
  parameter int NT = 4
) (
  input  logic [N-1:0]   pend_i,
  input  logic [N-1:0]   vvalid_i,
  input  logic [2*N-1:0] vthr_i,
  output logic [NT-1:0]  trig_o
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [N-1:0] hit;
    for (genvar i = 0; i < N; i++) begin : g_line
      assign hit[i] = pend_i[i] & vvalid_i[i] & (vthr_i[2*i +: 2] == 2'(t));
    end
    assign trig_o[t] = |hit;
  end
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*32-1:0]     irq_in,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [15:0]                 reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic                        reg_rvalid,
  output logic [3:0]                  thr_trig
);
  localparam int N = NUM_BANKS * LINES_PER_BANK;

  reg_sel_t      sel;
  logic [N-1:0]  sync_w, rise_w, status_w, sense_w, mask_w, pend_w, tog_w, vvalid_w;
  logic [2*N-1:0] vthr_w;
  logic [31:0]   rd_mux;

  assign sel = decode_addr(reg_addr, NUM_BANKS);

  trig_sync #(.W(N)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(irq_in), .sync_o(sync_w), .rise_o(rise_w)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_b;
    assign hit_b = reg_wr && (sel.bank == 2'(b));
    trig_bank bank_i (
      .clk(clk), .rst_n(rst_n),
      .sync_i(sync_w[32*b +: 32]),
      .rise_i(rise_w[32*b +: 32]),
      .stat_we(hit_b && sel.kind == SEL_STAT),
      .sens_we(hit_b && sel.kind == SEL_SENS),
      .mask_we(hit_b && sel.kind == SEL_MASK),
      .vec_we (hit_b && sel.kind == SEL_VEC),
      .vec_bit(sel.bitn),
      .wdata(reg_wdata),
      .status_o(status_w[32*b +: 32]),
      .sense_o (sense_w[32*b +: 32]),
      .mask_o  (mask_w[32*b +: 32]),
      .pend_o  (pend_w[32*b +: 32]),
      .tog_o   (tog_w[32*b +: 32]),
      .vvalid_o(vvalid_w[32*b +: 32]),
      .vthr_o  (vthr_w[64*b +: 64])
    );
  end

  trig_route #(.N(N), .NT(NUM_THREADS)) route_i (
    .pend_i(pend_w), .vvalid_i(vvalid_w), .vthr_i(vthr_w), .trig_o(thr_trig)
  );

  always_comb begin
    rd_mux = 32'd0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel.bank == 2'(b)) begin
        case (sel.kind)
          SEL_STAT: rd_mux = status_w[32*b +: 32];
          SEL_SENS: rd_mux = sense_w[32*b +: 32];
          SEL_MASK: rd_mux = mask_w[32*b +: 32];
          SEL_VEC:  rd_mux = vec_word(vvalid_w[32*b + int'(sel.bitn)],
                                      vthr_w[2*(32*b + int'(sel.bitn)) +: 2]);
          default:  rd_mux = 32'd0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      reg_rdata  <= reg_rd ? rd_mux : 32'd0;
    end
  end
endmodule

// File: rtl/trig_ctrl_chk.sv
module trig_ctrl_chk #(
  parameter int N = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] status_w,
  input logic [N-1:0] sense_w,
  input logic [N-1:0] sync_w,
  input logic [N-1:0] rise_w,
  input logic [N-1:0] tog_w,
  input logic [N-1:0] pend_w,
  input logic [3:0]   thr_trig
);
  // R3
  edge_rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_w & $past(rise_w & ~sense_w)) == $past(rise_w & ~sense_w)));

  // R4
  edge_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status_w ^ $past(status_w)) & $past(~sense_w & ~rise_w))
              == $past(tog_w & ~sense_w & ~rise_w)));

  // R5
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_w & $past(sense_w)) == $past(sync_w & sense_w)));

  // R6
  trig_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_trig != 4'd0) |-> (pend_w != '0));

  // R8
  trig_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pend_w) <= 1) |-> $onehot0(thr_trig));
endmodule

bind trig_ctrl trig_ctrl_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .status_w(status_w), .sense_w(sense_w),
  .sync_w(sync_w), .rise_w(rise_w), .tog_w(tog_w), .pend_w(pend_w),
  .thr_trig(thr_trig)
);

// File: tb/trig_ctrl_tb_top.sv
module trig_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int N  = NB * 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [3:0]  thr_trig;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [15:0] addr;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_ctrl #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .thr_trig(thr_trig)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (reg_rvalid) begin
      n_vec++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read data: actual %h expected none", reg_rdata);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        if (reg_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s addr %h: actual %h expected %h", it.tag, it.addr, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.addr = a; it.tag = tag;
    sb_q.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic chk_trig(input logic [3:0] e, input string tag);
    n_vec++;
    if (thr_trig !== e) begin
      n_bad++;
      $display("FAIL %s thr_trig: actual %b expected %b", tag, thr_trig, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset values
    chk_trig(4'b0000, "R1");
    rd(16'h0000, 32'h0, "R1 status");
    rd(16'h0040, 32'h0, "R1 sense");
    rd(16'h0080, 32'h0, "R1 mask");
    rd(16'h1000, 32'h0, "R1 vector");

    // R7 vector keeps only valid and thread bits
    wr(16'h1018, 32'hFFFF_FFFF);
    rd(16'h1018, 32'h0000_0013, "R7 vector bits");
    wr(16'h1018, 32'h12);          // line 3 -> thread 2
    wr(16'h0080, 32'h8);

    // R3 edge latency: visible on third edge
    irq_in[3] = 1'b1;
    tick(2);
    chk_trig(4'b0000, "R3 early");
    tick(1);
    chk_trig(4'b0100, "R3 R8 on time");
    rd(16'h0000, 32'h8, "R3 status");

    // R4 toggle semantics
    wr(16'h0000, 32'h8);
    rd(16'h0000, 32'h0, "R4 flip clear");
    chk_trig(4'b0000, "R4 cleared");
    wr(16'h0000, 32'h8);
    rd(16'h0000, 32'h8, "R4 flip set");
    wr(16'h0000, 32'h0);
    rd(16'h0000, 32'h8, "R4 zero write");
    wr(16'h0000, 32'h8);
    rd(16'h0000, 32'h0, "R4 clear again");

    // R4 rise coinciding with flip while set: ends set
    wr(16'h0000, 32'h20);
    irq_in[5] = 1'b1;
    tick(2);
    wr(16'h0000, 32'h20);
    rd(16'h0000, 32'h20, "R4 rise beats toggle");
    wr(16'h0000, 32'h20);

    // R6 masking keeps recording
    wr(16'h2040, 32'h11);          // line 40 -> thread 1
    irq_in[40] = 1'b1;
    tick(4);
    chk_trig(4'b0000, "R6 masked");
    rd(16'h0008, 32'h100, "R6 status recorded");
    wr(16'h0088, 32'h100);
    chk_trig(4'b0010, "R6 unmasked");

    // R7 invalid vector disconnects
    wr(16'h2040, 32'h01);
    chk_trig(4'b0000, "R7 disconnected");
    rd(16'h2040, 32'h1, "R7 vector readback");
    rd(16'h0008, 32'h100, "R7 status kept");

    // R8 reroute and OR of two lines
    wr(16'h2040, 32'h13);
    chk_trig(4'b1000, "R8 single thread");
    wr(16'h3030, 32'h13);          // line 70 -> thread 3
    wr(16'h0090, 32'h40);
    wr(16'h0010, 32'h40);
    chk_trig(4'b1000, "R8 two lines");
    wr(16'h0008, 32'h100);
    chk_trig(4'b1000, "R8 one remains");
    wr(16'h0010, 32'h40);
    chk_trig(4'b0000, "R8 none");

    // R5 level line
    wr(16'h0048, 32'h200);
    rd(16'h0048, 32'h200, "R2 sense bank1");
    wr(16'h2048, 32'h10);          // line 41 -> thread 0
    wr(16'h0088, 32'h300);
    irq_in[41] = 1'b1;
    tick(2);
    chk_trig(4'b0000, "R5 early");
    tick(1);
    chk_trig(4'b0001, "R5 follows");
    wr(16'h0008, 32'h200);
    rd(16'h0008, 32'h200, "R5 write ignored");
    irq_in[41] = 1'b0;
    tick(3);
    chk_trig(4'b0000, "R5 drops");
    rd(16'h0008, 32'h0, "R5 status low");

    // R9 / R2 unbuilt bank and unmapped offsets
    wr(16'h0018, 32'hFFFF_FFFF);
    rd(16'h0018, 32'h0, "R9 status bank3");
    wr(16'h4000, 32'h13);
    rd(16'h4000, 32'h0, "R9 vector bank3");
    wr(16'h0004, 32'hFFFF_FFFF);
    rd(16'h0004, 32'h0, "R2 unaligned");
    rd(16'h0080, 32'h8, "R2 mask bank0 untouched");

    tick(3);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d reads pending expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule